// File: doc/BRIEF.md
# Differential Two-Bit Symbol Encoder

This block encodes a stream of two-bit input symbols, one in-phase bit and one quadrature bit, into a stream of two-bit output symbols. The information sits in the change between output symbols and not in their absolute value. Each accepted input symbol selects which of the two output bits flip relative to the output symbol sent before it. When exactly one input bit is set, the choice of bit to flip also depends on whether the two previous output bits matched.

An upstream source presents a symbol together with a valid strobe. One clock later the encoded symbol appears on registered outputs with its own valid flag. On cycles without a valid symbol, the stored output pair and the outputs stay as they are. The reset input asserts asynchronously. Its release is synchronised to the clock inside the block.

Top module: `diffenc_top`

## Requirements
- R1: While reset is held, out_i and out_q are 0 and out_vld is 0.
- R2: An accepted symbol with in_i=1 and in_q=1 inverts both output bits relative to the previous output pair.
- R3: An accepted symbol with in_i=0 and in_q=0 leaves the output pair equal to the previous output pair.
- R4: An accepted symbol with exactly one input bit set, when the previous out_i equals the previous out_q, inverts only the output bit whose input bit is 0.
- R5: An accepted symbol with exactly one input bit set, when the previous out_i differs from the previous out_q, inverts only the output bit whose input bit is 1.
- R6: out_vld is 1 exactly in the cycle after a cycle with in_vld=1, and 0 in the cycle after a cycle with in_vld=0.
- R7: A cycle with in_vld=0 has no effect on the output pair, whatever in_i and in_q carry.
- R8: Driving rst_n low clears the outputs at once, without a clock edge. After rst_n rises, the block ignores in_vld until SYNC_STAGES rising clock edges have passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| in_vld | input | 1 | Input symbol valid strobe |
| in_i | input | 1 | In-phase input bit |
| in_q | input | 1 | Quadrature input bit |
| out_vld | output | 1 | Output symbol valid, one cycle after in_vld |
| out_i | output | 1 | Encoded in-phase bit |
| out_q | output | 1 | Encoded quadrature bit |

## Verification
The hardest case to reach is a single-one input arriving in each of the four possible previous output states. The equal and unequal branches both have to be seen with each of the two single-one inputs. Random inputs only pass through the unequal states (01 and 10) by chance. For that reason, a directed prefix first walks the pair from 00 through 01, 11 and 10, applying both single-one inputs along the way. A long random run follows, with valid bursts and idle gaps whose inputs carry garbage, and it is compared on every cycle with a behavioural model.

// File: rtl/diffenc_pkg.sv
package diffenc_pkg;
  localparam int SYM_W = 2;
  localparam int I_BIT = 1;
  localparam int Q_BIT = 0;
  typedef logic [SYM_W-1:0] sym_t;
endpackage

// File: rtl/diffenc_rst_sync.sv
module diffenc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/diffenc_flip_sel.sv
module diffenc_flip_sel
  import diffenc_pkg::*;
(
  input  sym_t din,
  input  sym_t prev,
  output sym_t flip
);
  logic prev_same;
  assign prev_same = (prev[I_BIT] == prev[Q_BIT]);

  always_comb begin
    flip = '0;
    unique case (din)
      2'b11: flip = 2'b11;
      2'b00: flip = 2'b00;
      default: begin
        if (prev_same) flip = ~din;
        else           flip = din;
      end
    endcase
  end

  // R4 R5: a single-one input flips exactly one bit
  always_comb begin
    if (din == 2'b01 || din == 2'b10) begin
      single_flip_chk: assert ($countones(flip) == 1);
    end
  end
endmodule

// File: rtl/diffenc_state.sv
module diffenc_state
  import diffenc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  sym_t flip,
  output sym_t cur,
  output logic vld
);
  sym_t cur_q, cur_d;
  logic vld_q, vld_d;

  always_comb begin
    cur_d = cur_q;
    if (en) cur_d = cur_q ^ flip;
    vld_d = en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      if (en) cur_q <= cur_d;
    end
  end

  assign cur = cur_q;
  assign vld = vld_q;

  // R7: the stored pair only moves on an enabled cycle
  hold_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(cur_q));
endmodule

// File: rtl/diffenc_top.sv
module diffenc_top
  import diffenc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_vld,
  input  logic in_i,
  input  logic in_q,
  output logic out_vld,
  output logic out_i,
  output logic out_q
);
  logic srst_n;
  sym_t din, flip, cur;

  assign din[I_BIT] = in_i;
  assign din[Q_BIT] = in_q;

  diffenc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n));

  diffenc_flip_sel u_sel (.din(din), .prev(cur), .flip(flip));

  diffenc_state u_st (
    .clk(clk), .rst_n(srst_n), .en(in_vld), .flip(flip),
    .cur(cur), .vld(out_vld));

  assign out_i = cur[I_BIT];
  assign out_q = cur[Q_BIT];

  // R6
  vld_follow_chk: assert property (@(posedge clk) disable iff (!srst_n)
    in_vld |=> out_vld);
  // R6
  vld_drop_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !in_vld |=> !out_vld);
  // R2
  both_flip_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (in_vld && in_i && in_q) |=> (out_i != $past(out_i)) && (out_q != $past(out_q)));
  // R3
  no_flip_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (in_vld && !in_i && !in_q) |=> $stable(out_i) && $stable(out_q));
  // R4
  same_prev_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (in_vld && (in_i ^ in_q) && (out_i == out_q)) |=> (out_i != $past(out_i)) == !$past(in_i));
  // R5
  diff_prev_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (in_vld && (in_i ^ in_q) && (out_i != out_q)) |=> (out_i != $past(out_i)) == $past(in_i));
endmodule

// File: tb/diffenc_top_test.sv
module diffenc_top_test;
  localparam int SYNC = 2;
  logic clk = 1'b0;
  logic rst_n, in_vld, in_i, in_q;
  logic out_vld, out_i, out_q;
  int checks = 0, fails = 0, cycles = 0;
  int exp_pair = 0;
  int exp_v = 0;
  string tag = "R1";

  diffenc_top #(.SYNC_STAGES(SYNC)) uut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_i(in_i), .in_q(in_q),
    .out_vld(out_vld), .out_i(out_i), .out_q(out_q));

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL R6 watchdog expired actual=%0d cycles expected=done", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", r, act, exp, $time);
    end
  endtask

  function automatic int ref_next(input int prev, input int i, input int q);
    int pi = prev / 2;
    int pq = prev % 2;
    if (i == 1 && q == 1) begin pi = 1 - pi; pq = 1 - pq; end
    else if (i != q) begin
      if (pi == pq) begin
        if (i == 0) pi = 1 - pi; else pq = 1 - pq;
      end else begin
        if (i == 1) pi = 1 - pi; else pq = 1 - pq;
      end
    end
    return pi * 2 + pq;
  endfunction

  task automatic step(input bit v, input bit i, input bit q);
    int prev;
    @(negedge clk);
    check({out_i, out_q} == exp_pair[1:0], tag, {out_i, out_q}, exp_pair);
    check(out_vld == exp_v[0], "R6", out_vld, exp_v);
    in_vld = v; in_i = i; in_q = q;
    prev = exp_pair;
    if (v) begin
      exp_pair = ref_next(prev, i, q);
      exp_v = 1;
      if (i && q) tag = "R2";
      else if (!i && !q) tag = "R3";
      else if ((prev / 2) == (prev % 2)) tag = "R4";
      else tag = "R5";
    end else begin
      exp_v = 0;
      tag = "R7";
    end
  endtask

  initial begin
    rst_n = 1'b0; in_vld = 1'b1; in_i = 1'b1; in_q = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs cleared while reset is held, even with valid high
    check({out_vld, out_i, out_q} == 3'b000, "R1", {out_vld, out_i, out_q}, 0);
    rst_n = 1'b1;
    // R8: valid ignored during synchronised release
    for (int k = 0; k < SYNC; k++) begin
      @(negedge clk);
      check({out_vld, out_i, out_q} == 3'b000, "R8", {out_vld, out_i, out_q}, 0);
    end
    in_vld = 1'b0;
    exp_pair = 0; exp_v = 0; tag = "R8";
    step(0, 0, 0);
    // directed walk through equal and unequal previous states
    step(1, 1, 0);   // 00 same -> flip Q -> 01
    step(1, 1, 0);   // 01 diff -> flip I -> 11
    step(1, 0, 1);   // 11 same -> flip I -> 01
    step(1, 0, 1);   // 01 diff -> flip Q -> 00
    step(1, 0, 1);   // 00 same -> flip I -> 10
    step(1, 1, 0);   // 10 diff -> flip I -> 00
    step(1, 1, 1);   // -> 11
    step(1, 0, 0);   // hold 11
    step(0, 1, 1);   // ignored
    step(0, 1, 0);   // ignored
    step(1, 1, 0);   // 11 same -> flip Q -> 10
    step(1, 0, 1);   // 10 diff -> flip Q -> 11
    step(0, 0, 0);
    // random bursts and idle gaps
    for (int n = 0; n < 3000; n++) begin
      bit v = ($urandom_range(0, 9) < 6);
      step(v, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end
    // R8: asynchronous clear between edges
    @(negedge clk);
    #2 rst_n = 1'b0;
    #1 check({out_vld, out_i, out_q} == 3'b000, "R8", {out_vld, out_i, out_q}, 0);
    in_vld = 1'b1; in_i = 1'b1; in_q = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (SYNC) @(negedge clk);
    check({out_vld, out_i, out_q} == 3'b000, "R8", {out_vld, out_i, out_q}, 0);
    in_vld = 1'b0;
    exp_pair = 0; exp_v = 0; tag = "R1";
    step(0, 0, 0);
    step(1, 1, 1);
    step(1, 1, 0);
    step(0, 0, 0);
    step(0, 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule